// File: doc/BRIEF.md
# Asynchronous Serial Port With Loopback Error Injection

This block is a single-character, full-duplex asynchronous serial port. A transmitter turns a written byte into a frame on the transmit line: a low start bit, seven or eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. A receiver hunts for start bits on the receive line and checks each incoming frame for parity, framing and overrun faults. Both directions run from one oversampling tick that an 8-bit reload counter produces. The tick comes at sixteen times the bit rate. The counter runs free of bus traffic and freezes while the halt input is high.

Software works through four byte registers on a simple read/write strobe interface. Address 0 holds the data: a write loads the transmit holding byte and a read returns the last received character. Address 1 holds the status, address 2 the control byte and address 3 the baud reload value. A loopback control bit feeds the transmitter straight into the receiver. While it is set, three more control bits can corrupt the looped character on purpose: a wrong parity bit, low stop bits, or a forced overrun. Driver error paths can then be tested without outside hardware.

Top module: `async_serial_port`

## Requirements
- R1: After reset the status register (address 1) reads 0x30 and the transmit line is high. The status bits are: bit0 receive full, bit1 parity error, bit2 framing error, bit3 overrun, bit4 holding register empty, bit5 transmitter idle (holding register empty and no frame in progress).
- R2: A byte written to address 0 is sent as a low start bit, then the data bits LSB first, then the stop bits, and the line returns high afterwards. Control bit0 selects 8 data bits (1) or 7 data bits (0). Control bit1 selects 2 stop bits (1) or 1 stop bit (0).
- R3: With control bit2 set, a parity bit follows the last data bit. Control bit3 = 0 selects even parity, which makes the count of ones over the data and parity bits even. Control bit3 = 1 selects odd parity.
- R4: Every bit lasts 16 ticks, and one tick lasts (reload + 1) clocks. The reload value sits at address 3.
- R5: A falling edge on the receive line starts a character only if the line is still low 8 ticks later. A shorter low pulse leaves the receiver empty.
- R6: A received character sets status bit0 and can be read at address 0. In 7-bit mode bit7 reads 0. A read of address 0 clears bit0, and the stored character stays unchanged until it is read.
- R7: Status bit1 is set when the received parity bit does not match the selected parity.
- R8: Status bit2 is set when any stop bit of a received frame is sampled low.
- R9: If a character completes while bit0 is still set, status bit3 is set, the new character is discarded and the unread one is kept.
- R10: Control bit4 (loopback) routes the transmitter into the receiver, holds the transmit pin high and ignores the receive pin.
- R11: In loopback, control bit5 inverts the sent parity bit, control bit6 sends the stop bits low, and control bit7 reports the looped character as an overrun and discards it.
- R12: While the halt input is high the tick stops: no frame starts or advances, and the transmit line and receive state hold. Operation resumes when halt falls.
- R13: A read of the status register clears bits 1 to 3. An error that arrives on the same cycle as that read still gets recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| halt_i | input | 1 | Freezes the baud tick while high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (used for read side effects) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |

## Verification
The bench checks the transmit pin bit by bit at mid-bit for 8N1, 7E2 and 8O1 frames and at two reload values. A wrong bit order, parity sense, stop count or bit length shows up there as a mismatched bit. On the receive side it drives a glitch shorter than half a bit, which a receiver without start confirmation would take in as a bogus 0xFF or 0x7F character. It also drives frames with bad parity and a low stop bit, and it checks that a second unread character raises overrun while the first byte is kept, not overwritten. In loopback it forces each of the three errors in turn, checks that the flags clear on a status read, and holds halt across a pending write, where a counter that ignored halt would let the character arrive early.

// File: rtl/asp_pkg.sv
package asp_pkg;

    localparam int OVS   = 16;
    localparam int OVS_W = $clog2(OVS);

    // frame format, low nibble of the control byte
    typedef struct packed {
        logic par_odd;
        logic par_en;
        logic stop2;
        logic len8;
    } frame_cfg_t;

    // full control byte
    typedef struct packed {
        logic       frc_ovr;
        logic       frc_frm;
        logic       frc_par;
        logic       loop;
        frame_cfg_t fmt;
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_CTRL = 2'd2,
        REG_DIV  = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_WAITHI, RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    function automatic logic parity_of(input logic [7:0] d, input frame_cfg_t c);
        logic p;
        p = ^(c.len8 ? d : {1'b0, d[6:0]});
        return p ^ c.par_odd;
    endfunction

    function automatic logic [2:0] last_bit(input frame_cfg_t c);
        return c.len8 ? 3'd7 : 3'd6;
    endfunction

endpackage

// File: rtl/asp_baud.sv
module asp_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             halt_i,
    input  logic [DIV_W-1:0] reload_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = !halt_i && (cnt_q == '0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (!halt_i) begin
            if (cnt_q == '0) cnt_q <= reload_i;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  frame_cfg_t cfg_i,
    input  logic       frc_par_i,
    input  logic       frc_frm_i,
    input  logic       load_req_i,
    input  logic [7:0] data_i,
    output logic       take_o,
    output logic       busy_o,
    output logic       line_o
);
    tx_state_e        state_q;
    logic [OVS_W-1:0] sub_q;
    logic [2:0]       idx_q;
    logic             second_q;
    logic [7:0]       sh_q;
    frame_cfg_t       cfg_q;
    logic             fpar_q;
    logic             ffrm_q;
    logic             line_q;

    assign take_o = tick_i && (state_q == TX_IDLE) && load_req_i;
    assign busy_o = (state_q != TX_IDLE);
    assign line_o = line_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= TX_IDLE;
            sub_q    <= '0;
            idx_q    <= '0;
            second_q <= 1'b0;
            sh_q     <= '0;
            cfg_q    <= '0;
            fpar_q   <= 1'b0;
            ffrm_q   <= 1'b0;
            line_q   <= 1'b1;
        end else if (tick_i) begin
            if (state_q == TX_IDLE) begin
                if (load_req_i) begin
                    sh_q    <= data_i;
                    cfg_q   <= cfg_i;
                    fpar_q  <= frc_par_i;
                    ffrm_q  <= frc_frm_i;
                    sub_q   <= '0;
                    line_q  <= 1'b0;
                    state_q <= TX_START;
                end
            end else begin
                sub_q <= sub_q + 1'b1;
                if (sub_q == OVS_W'(OVS - 1)) begin
                    sub_q <= '0;
                    case (state_q)
                        TX_START: begin
                            state_q <= TX_DATA;
                            idx_q   <= '0;
                            line_q  <= sh_q[0];
                        end
                        TX_DATA: begin
                            if (idx_q == last_bit(cfg_q)) begin
                                if (cfg_q.par_en) begin
                                    state_q <= TX_PAR;
                                    line_q  <= parity_of(sh_q, cfg_q) ^ fpar_q;
                                end else begin
                                    state_q  <= TX_STOP;
                                    second_q <= 1'b0;
                                    line_q   <= ~ffrm_q;
                                end
                            end else begin
                                idx_q  <= idx_q + 3'd1;
                                line_q <= sh_q[idx_q + 3'd1];
                            end
                        end
                        TX_PAR: begin
                            state_q  <= TX_STOP;
                            second_q <= 1'b0;
                            line_q   <= ~ffrm_q;
                        end
                        default: begin
                            if (cfg_q.stop2 && !second_q) begin
                                second_q <= 1'b1;
                            end else begin
                                state_q <= TX_IDLE;
                                line_q  <= 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       line_i,
    input  frame_cfg_t cfg_i,
    output logic       done_o,
    output logic [7:0] data_o,
    output logic       perr_o,
    output logic       ferr_o
);
    logic             s1_q, s2_q;
    rx_state_e        state_q;
    logic [OVS_W-1:0] sub_q;
    logic [2:0]       idx_q;
    logic             second_q;
    logic [7:0]       sh_q;
    frame_cfg_t       cfg_q;
    logic             perr_q, ferr_q, done_q;

    assign done_o = done_q;
    assign data_o = sh_q;
    assign perr_o = perr_q;
    assign ferr_o = ferr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q  <= RX_WAITHI;
            sub_q    <= '0;
            idx_q    <= '0;
            second_q <= 1'b0;
            sh_q     <= '0;
            cfg_q    <= '0;
            perr_q   <= 1'b0;
            ferr_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick_i) begin
                sub_q <= sub_q + 1'b1;
                case (state_q)
                    RX_WAITHI: if (s2_q) state_q <= RX_IDLE;
                    RX_IDLE: begin
                        if (!s2_q) begin
                            state_q <= RX_START;
                            sub_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (sub_q == OVS_W'(OVS / 2 - 1)) begin
                            sub_q <= '0;
                            if (!s2_q) begin
                                state_q <= RX_DATA;
                                idx_q   <= '0;
                                sh_q    <= '0;
                                cfg_q   <= cfg_i;
                                perr_q  <= 1'b0;
                                ferr_q  <= 1'b0;
                            end else begin
                                state_q <= RX_IDLE;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (sub_q == OVS_W'(OVS - 1)) begin
                            sh_q[idx_q] <= s2_q;
                            if (idx_q == last_bit(cfg_q)) begin
                                state_q  <= cfg_q.par_en ? RX_PAR : RX_STOP;
                                second_q <= 1'b0;
                            end else begin
                                idx_q <= idx_q + 3'd1;
                            end
                        end
                    end
                    RX_PAR: begin
                        if (sub_q == OVS_W'(OVS - 1)) begin
                            perr_q  <= s2_q ^ parity_of(sh_q, cfg_q);
                            state_q <= RX_STOP;
                        end
                    end
                    default: begin
                        if (sub_q == OVS_W'(OVS - 1)) begin
                            ferr_q <= ferr_q | !s2_q;
                            if (cfg_q.stop2 && !second_q) begin
                                second_q <= 1'b1;
                            end else begin
                                done_q  <= 1'b1;
                                state_q <= RX_WAITHI;
                            end
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
    import asp_pkg::*;
#(
    parameter int               DIV_W     = 8,
    parameter logic [DIV_W-1:0] RESET_DIV = DIV_W'(1)
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       halt_i,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [1:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       txd_o,
    input  logic       rxd_i
);
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       thr_q;
    logic             thr_full;
    logic [7:0]       rx_data_q;
    logic             rx_full, perr_q, ferr_q, ovr_q;

    logic       tick, take, tx_busy, tx_line;
    logic       rx_done, rx_perr, rx_ferr;
    logic [7:0] rx_data;

    reg_addr_e addr;
    assign addr = reg_addr_e'(addr_i);

    logic data_wr, data_rd, stat_rd, blocked, accept, ovr_event;
    assign data_wr   = wr_en_i && addr == REG_DATA;
    assign data_rd   = rd_en_i && addr == REG_DATA;
    assign stat_rd   = rd_en_i && addr == REG_STAT;
    assign blocked   = (rx_full && !data_rd) || (ctrl_q.loop && ctrl_q.frc_ovr);
    assign accept    = rx_done && !blocked;
    assign ovr_event = rx_done && blocked;

    asp_baud #(.DIV_W(DIV_W)) u_baud (
        .clk_i(clk_i), .rst_i(rst_i), .halt_i(halt_i),
        .reload_i(div_q), .tick_o(tick)
    );

    asp_tx u_tx (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .cfg_i(ctrl_q.fmt),
        .frc_par_i(ctrl_q.loop && ctrl_q.frc_par),
        .frc_frm_i(ctrl_q.loop && ctrl_q.frc_frm),
        .load_req_i(thr_full), .data_i(thr_q),
        .take_o(take), .busy_o(tx_busy), .line_o(tx_line)
    );

    asp_rx u_rx (
        .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick),
        .line_i(ctrl_q.loop ? tx_line : rxd_i), .cfg_i(ctrl_q.fmt),
        .done_o(rx_done), .data_o(rx_data), .perr_o(rx_perr), .ferr_o(rx_ferr)
    );

    assign txd_o = ctrl_q.loop ? 1'b1 : tx_line;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q    <= '0;
            div_q     <= RESET_DIV;
            thr_q     <= '0;
            thr_full  <= 1'b0;
            rx_data_q <= '0;
            rx_full   <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (wr_en_i && addr == REG_CTRL) ctrl_q <= ctrl_t'(wdata_i);
            if (wr_en_i && addr == REG_DIV)  div_q  <= DIV_W'(wdata_i);
            if (data_wr) begin
                thr_q    <= wdata_i;
                thr_full <= 1'b1;
            end else if (take) begin
                thr_full <= 1'b0;
            end
            rx_full <= accept | (rx_full & ~data_rd);
            if (accept) rx_data_q <= rx_data;
            if (stat_rd) begin
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (accept && rx_perr) perr_q <= 1'b1;
            if (accept && rx_ferr) ferr_q <= 1'b1;
            if (ovr_event)         ovr_q  <= 1'b1;
        end
    end

    logic [7:0] status;
    assign status = {2'b00, ~tx_busy & ~thr_full, ~thr_full, ovr_q, ferr_q, perr_q, rx_full};

    always_comb begin
        case (addr)
            REG_DATA: rdata_o = rx_data_q;
            REG_STAT: rdata_o = status;
            REG_CTRL: rdata_o = ctrl_q;
            default:  rdata_o = 8'(div_q);
        endcase
    end
endmodule

// File: rtl/asp_checker.sv
module asp_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       halt_i,
    input logic       wr_en_i,
    input logic       txd_o,
    input logic       rx_full,
    input logic       data_rd,
    input logic       data_wr,
    input logic       rx_done,
    input logic       ovr_q,
    input logic [7:0] rx_data_q,
    input logic       tx_busy,
    input logic       tx_line,
    input logic       thr_full
);
    // R12
    halt_txd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        halt_i && !wr_en_i |=> $stable(txd_o));

    // R12
    halt_rx_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        halt_i && !data_rd && !rx_done |=> $stable(rx_full));

    // R9
    overrun_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_done && rx_full && !data_rd |=> ovr_q && rx_full);

    // R6
    rx_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_full && !data_rd |=> $stable(rx_data_q));

    // R2
    idle_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tx_busy |-> tx_line);

    // R2
    thr_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        data_wr && !thr_full |=> thr_full);
endmodule

bind async_serial_port asp_checker u_asp_chk (
    .clk_i(clk_i), .rst_i(rst_i), .halt_i(halt_i), .wr_en_i(wr_en_i),
    .txd_o(txd_o), .rx_full(rx_full), .data_rd(data_rd), .data_wr(data_wr),
    .rx_done(rx_done), .ovr_q(ovr_q), .rx_data_q(rx_data_q),
    .tx_busy(tx_busy), .tx_line(tx_line), .thr_full(thr_full)
);

// File: tb/async_serial_port_bench.sv
`timescale 1ns/1ps
module async_serial_port_bench;
    logic       clk = 1'b0;
    logic       rst, halt, wr_en, rd_en, rxd;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic       txd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    async_serial_port u_async_serial_port (
        .clk_i(clk), .rst_i(rst), .halt_i(halt), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .txd_o(txd), .rxd_i(rxd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v === exp, req, v, exp);
    endtask

    function automatic int mk_frame(input logic [7:0] d, input bit len8, input bit pe,
                                    input bit odd, input bit st2, input bit bad_par,
                                    input bit bad_stop, output bit [11:0] fr);
        int n = 0;
        int nd = len8 ? 8 : 7;
        bit p = odd ^ bad_par;
        fr = '0;
        fr[n++] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            fr[n++] = d[i];
            p ^= d[i];
        end
        if (pe) fr[n++] = p;
        fr[n++] = ~bad_stop;
        if (st2) fr[n++] = ~bad_stop;
        return n;
    endfunction

    task automatic drive_rx(input logic [7:0] d, input bit len8, input bit pe, input bit odd,
                            input bit st2, input bit bad_par, input bit bad_stop, input int bt);
        bit [11:0] fr;
        int n = mk_frame(d, len8, pe, odd, st2, bad_par, bad_stop, fr);
        for (int i = 0; i < n; i++) begin
            rxd = fr[i];
            clocks(bt);
        end
        rxd = 1'b1;
        clocks(2 * bt);
    endtask

    task automatic watch_tx(input logic [7:0] d, input bit len8, input bit pe, input bit odd,
                            input bit st2, input int bt, input string req);
        bit [11:0] fr;
        int n = mk_frame(d, len8, pe, odd, st2, 1'b0, 1'b0, fr);
        int t = 0;
        while (txd !== 1'b0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        check(txd === 1'b0, {req, " start bit"}, txd, 0);
        clocks(bt / 2);
        for (int i = 0; i < n; i++) begin
            check(txd === fr[i], req, txd, fr[i]);
            clocks(bt);
        end
        check(txd === 1'b1, {req, " idle after frame"}, txd, 1);
    endtask

    // R1
    task automatic t_reset();
        expect_reg(2'd1, 8'h30, "R1 status after reset");
        check(txd === 1'b1, "R1 txd idle high", txd, 1);
    endtask

    // R2 R3 R4: transmit frames seen on the pin
    task automatic t_tx_wave();
        wr(2'd3, 8'd1);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h3C);
        watch_tx(8'h3C, 1, 0, 0, 0, 32, "R2 8N1 frame");
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h55);
        watch_tx(8'h55, 0, 1, 0, 1, 32, "R3 7E2 frame");
        wr(2'd3, 8'd3);
        wr(2'd2, 8'h0D);
        wr(2'd0, 8'h81);
        watch_tx(8'h81, 1, 1, 1, 0, 64, "R4 8O1 frame at reload 3");
        wr(2'd3, 8'd1);
        clocks(100);
    endtask

    // R10 R6: loopback
    task automatic t_loop_basic();
        int bad = 0;
        wr(2'd2, 8'h11);
        rxd = 1'b0;
        wr(2'd0, 8'hA5);
        for (int i = 0; i < 13 * 32; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad++;
        end
        check(bad == 0, "R10 pin held high in loopback", bad, 0);
        rxd = 1'b1;
        expect_reg(2'd1, 8'h31, "R10 looped character received");
        expect_reg(2'd0, 8'hA5, "R6 looped data");
        expect_reg(2'd1, 8'h30, "R6 data read clears full");
    endtask

    // R5 R6 R7 R8: external receive
    task automatic t_rx_ext();
        wr(2'd2, 8'h05);
        drive_rx(8'h81, 1, 1, 0, 0, 0, 0, 32);
        expect_reg(2'd1, 8'h31, "R6 good 8E1 frame");
        expect_reg(2'd0, 8'h81, "R6 received data");
        drive_rx(8'h3E, 1, 1, 0, 0, 1, 0, 32);
        expect_reg(2'd1, 8'h33, "R7 parity error flagged");
        expect_reg(2'd0, 8'h3E, "R7 data kept");
        expect_reg(2'd1, 8'h30, "R13 parity flag cleared");
        drive_rx(8'hC3, 1, 1, 0, 0, 0, 1, 32);
        expect_reg(2'd1, 8'h35, "R8 framing error flagged");
        expect_reg(2'd0, 8'hC3, "R8 data kept");
        rxd = 1'b0;
        clocks(6);
        rxd = 1'b1;
        clocks(20 * 32);
        expect_reg(2'd1, 8'h30, "R5 short glitch ignored");
        wr(2'd2, 8'h00);
        drive_rx(8'hFF, 0, 0, 0, 0, 0, 0, 32);
        expect_reg(2'd0, 8'h7F, "R6 7-bit data bit7 zero");
    endtask

    // R9 R13
    task automatic t_overrun();
        wr(2'd2, 8'h11);
        wr(2'd0, 8'h11);
        clocks(13 * 32);
        wr(2'd0, 8'h22);
        clocks(13 * 32);
        expect_reg(2'd1, 8'h39, "R9 overrun flagged");
        expect_reg(2'd1, 8'h31, "R13 overrun cleared by status read");
        expect_reg(2'd0, 8'h11, "R9 first character kept");
    endtask

    // R11
    task automatic t_forced();
        wr(2'd2, 8'h35);
        wr(2'd0, 8'h5A);
        clocks(14 * 32);
        expect_reg(2'd1, 8'h33, "R11 forced parity error");
        expect_reg(2'd0, 8'h5A, "R11 forced parity data");
        wr(2'd2, 8'h55);
        wr(2'd0, 8'h0F);
        clocks(14 * 32);
        expect_reg(2'd1, 8'h35, "R11 forced framing error");
        expect_reg(2'd0, 8'h0F, "R11 forced framing data");
        wr(2'd2, 8'h95);
        wr(2'd0, 8'h77);
        clocks(14 * 32);
        expect_reg(2'd1, 8'h38, "R11 forced overrun, character dropped");
        expect_reg(2'd1, 8'h30, "R13 flags cleared");
    endtask

    // R12
    task automatic t_halt();
        wr(2'd2, 8'h01);
        halt = 1'b1;
        wr(2'd0, 8'h42);
        clocks(40 * 32);
        expect_reg(2'd1, 8'h00, "R12 nothing sent while halted");
        check(txd === 1'b1, "R12 line held while halted", txd, 1);
        wr(2'd2, 8'h11);
        halt = 1'b0;
        clocks(14 * 32);
        expect_reg(2'd1, 8'h31, "R12 resumes after halt");
        expect_reg(2'd0, 8'h42, "R12 data after halt");
    endtask

    initial begin
        rst = 1'b1; halt = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        rxd = 1'b1; addr = '0; wdata = '0;
        clocks(4);
        rst = 1'b0;
        clocks(2);
        t_reset();
        t_tx_wave();
        t_loop_basic();
        t_rx_ext();
        t_overrun();
        t_forced();
        t_halt();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule